// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block sits between a group of peripheral interrupt lines and a single CPU. Each of the eight level-sensitive request inputs carries its own 3-bit priority setting. The controller picks the best pending source and passes it to the CPU as one registered request line plus the source index as a vector. A source is passed on only while its priority is strictly above the current priority level held inside the controller.

The current level follows the nesting of handlers. When the CPU acknowledges a presented request, the old level is pushed onto an internal last-in-first-out stack and the level of the acknowledged source becomes current. An end-of-interrupt strobe pops the stack back into the current level. Software may also write the current level directly, for example to raise it to a ceiling around a critical section and lower it again. Such writes leave the stack alone. Because the request output is registered, a request that is already on the line when a ceiling write lands stays visible for that one cycle and can still be acknowledged. A correct stack then restores the ceiling when that nested handler ends.

Top module: `pic_top`

## Requirements
- R1: `irq_o` and `vec_o` are registered. In the cycle after any input change they show the arbitration result over the inputs and the current level of the previous cycle. `irq_o` is high only if some requesting source has priority strictly greater than `cpr_o`, and `vec_o` then gives that source's index (0 to 7).
- R2: A source whose priority setting is 0 never causes `irq_o`.
- R3: When several qualifying sources share the highest priority, the one with the lowest index is presented.
- R4: An `ack` while `irq_o` is high pushes the current level onto the stack. The next cycle, `cpr_o` equals the priority of the presented source and `irq_o` is low.
- R5: An `eoi` pops the top stack entry into `cpr_o`, whatever value software wrote since the matching push.
- R6: A write (`cpr_we` with `cpr_wdata`) sets `cpr_o` from the next cycle and does not touch the stack. A request already high on `irq_o` stays high in the cycle after the write and can still be acknowledged.
- R7: The stack holds 8 levels. A push onto a full stack drops the value and sets the sticky `ovf_o`, while `cpr_o` still takes the acknowledged level.
- R8: An `eoi` on an empty stack sets the sticky `unf_o` and loads 0 into `cpr_o`.
- R9: An `ack` while `irq_o` is low has no effect: neither `cpr_o` nor the stack changes.
- R10: Synchronous reset `rst` sets `cpr_o` to 0, empties the stack and clears `irq_o`, `vec_o`, `ovf_o` and `unf_o`.
- R11: When strobes coincide, an accepted `ack` wins over `eoi`, and `eoi` wins over a write. Only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 8 | Level request per source |
| src_prio | input | 24 | Priority per source, bits [3i+2:3i] for source i |
| ack | input | 1 | CPU acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| cpr_we | input | 1 | Current-level write enable |
| cpr_wdata | input | 3 | Current-level write value |
| irq_o | output | 1 | Registered request to the CPU |
| vec_o | output | 3 | Index of the presented source |
| cpr_o | output | 3 | Current priority level |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The bench replays the ceiling race. A request is on the line, software raises the level above it, and the CPU acknowledges anyway. Two end-of-interrupt strobes must then return first the ceiling and then the original level. A design that masked combinationally would drop the request, and one that pushed the stale level would lose the ceiling. Nine nested acknowledges drive the stack past full, and extra pops drive it past empty. A design that wrapped its pointer would restore wrong levels instead of raising the sticky flags. Ties between equal priorities, zero-priority sources, acknowledges with no request and coincident strobes are also forced. Long random runs cover the rest, where a wrong tie-break or precedence shows up as a vector or level mismatch.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_SRC   = 8;
    localparam int PRIO_W    = 3;
    localparam int STK_DEPTH = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SET  = 2'd3
    } lvl_op_t;

    // accepted acknowledge beats end-of-interrupt beats software write
    function automatic lvl_op_t pick_op(input logic ack_ok, input logic eoi,
                                        input logic we);
        if (ack_ok)   return OP_PUSH;
        else if (eoi) return OP_POP;
        else if (we)  return OP_SET;
        else          return OP_NONE;
    endfunction
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int N  = 8,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [PW-1:0]   floor_lvl,
    output logic            win_valid,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_lvl
);
    logic [PW-1:0] best;

    // strict compare while scanning upward keeps the lowest index on ties
    always_comb begin
        best      = floor_lvl;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (prio_flat[i*PW +: PW] > best)) begin
                best      = prio_flat[i*PW +: PW];
                win_valid = 1'b1;
                win_idx   = IW'(i);
            end
        end
        win_lvl = best;
    end

    // R2: the chosen source is requesting and has a nonzero priority
    a_r2_winner_real: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (req[win_idx] && (prio_flat[win_idx*PW +: PW] != '0)));

    // R1: the chosen level sits above the floor
    a_r1_above_floor: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_lvl > floor_lvl));
endmodule

// File: rtl/pic_prio_stack.sv
module pic_prio_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 3,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full,
    output logic         ovf,
    output logic         unf
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign pop_data = empty ? '0 : mem[AW'(cnt - CW'(1))];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                mem[AW'(cnt)] <= push_data;
                cnt           <= cnt + CW'(1);
            end
        end else if (pop) begin
            if (empty) unf <= 1'b1;
            else       cnt <= cnt - CW'(1);
        end
    end

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf);
    a_r7_full_push: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (full && ovf));
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (empty && unf));
    a_r7_push_fills: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> !empty);
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int PW    = PRIO_W,
    parameter int DEPTH = STK_DEPTH,
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    src_req,
    input  logic [N_SRC*PW-1:0] src_prio,
    input  logic                ack,
    input  logic                eoi,
    input  logic                cpr_we,
    input  logic [PW-1:0]       cpr_wdata,
    output logic                irq_o,
    output logic [IW-1:0]       vec_o,
    output logic [PW-1:0]       cpr_o,
    output logic                ovf_o,
    output logic                unf_o
);
    logic [PW-1:0] cpr_q;
    logic          irq_q;
    logic [IW-1:0] vec_q;
    logic [PW-1:0] lvl_q;

    logic          win_valid;
    logic [IW-1:0] win_idx;
    logic [PW-1:0] win_lvl;
    logic [PW-1:0] pop_data;
    logic          stk_empty, stk_full;
    logic          ack_ok;
    lvl_op_t       op;

    assign ack_ok = ack && irq_q;
    assign op     = pick_op(ack_ok, eoi, cpr_we);

    pic_arbiter #(.N(N_SRC), .PW(PW)) i_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (src_req),
        .prio_flat (src_prio),
        .floor_lvl (cpr_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    pic_prio_stack #(.DEPTH(DEPTH), .W(PW)) i_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (op == OP_PUSH),
        .pop       (op == OP_POP),
        .push_data (cpr_q),
        .pop_data  (pop_data),
        .empty     (stk_empty),
        .full      (stk_full),
        .ovf       (ovf_o),
        .unf       (unf_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpr_q <= '0;
            irq_q <= 1'b0;
            vec_q <= '0;
            lvl_q <= '0;
        end else begin
            // registered presentation: masking by a new level lags one cycle
            irq_q <= win_valid && !ack_ok;
            vec_q <= win_idx;
            lvl_q <= win_lvl;
            unique case (op)
                OP_PUSH: cpr_q <= lvl_q;
                OP_POP:  cpr_q <= pop_data;
                OP_SET:  cpr_q <= cpr_wdata;
                default: cpr_q <= cpr_q;
            endcase
        end
    end

    assign irq_o = irq_q;
    assign vec_o = vec_q;
    assign cpr_o = cpr_q;

    // R4: accepted acknowledge installs the presented level and drops the line
    a_r4_ack_loads: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_q) |=> ((cpr_q == $past(lvl_q)) && !irq_q));
    // R9: acknowledge with nothing presented leaves the level alone
    a_r9_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_q && !eoi && !cpr_we) |=> $stable(cpr_q));
    // R6: a write that wins sets the level next cycle
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        (cpr_we && !ack_ok && !eoi) |=> (cpr_q == $past(cpr_wdata)));
    // R8: popping an empty stack clears the level
    a_r8_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack_ok && stk_empty) |=> (cpr_q == '0));
    // R2: a presented request never carries level 0
    a_r2_no_zero_lvl: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (lvl_q != '0));
endmodule

// File: tb/test_pic_top.sv
module test_pic_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  src_req;
    logic [23:0] src_prio;
    logic        ack, eoi, cpr_we;
    logic [2:0]  cpr_wdata;
    logic        irq_o;
    logic [2:0]  vec_o, cpr_o;
    logic        ovf_o, unf_o;

    always #5 clk = ~clk;

    pic_top i_pic_top (
        .clk(clk), .rst(rst), .src_req(src_req), .src_prio(src_prio),
        .ack(ack), .eoi(eoi), .cpr_we(cpr_we), .cpr_wdata(cpr_wdata),
        .irq_o(irq_o), .vec_o(vec_o), .cpr_o(cpr_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    bit       m_irq;
    int       m_vec, m_lvl, m_cpr, m_cnt;
    int       m_stk [8];
    bit       m_ovf, m_unf;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_irq = 0; m_vec = 0; m_lvl = 0; m_cpr = 0; m_cnt = 0;
        m_ovf = 0; m_unf = 0;
    endtask

    // one clock: apply inputs (already set), advance model, compare at negedge
    task automatic step(input string tag);
        bit ack_ok;
        bit n_irq;
        int best, idx, n_cpr;
        best = m_cpr; idx = 0; n_irq = 0;
        for (int i = 0; i < 8; i++) begin
            int p;
            p = int'(src_prio[i*3 +: 3]);
            if (src_req[i] && p > best) begin best = p; idx = i; n_irq = 1; end
        end
        ack_ok = ack && m_irq;
        n_cpr  = m_cpr;
        if (ack_ok) begin
            if (m_cnt == 8) m_ovf = 1;
            else begin m_stk[m_cnt] = m_cpr; m_cnt++; end
            n_cpr = m_lvl;
        end else if (eoi) begin
            if (m_cnt == 0) begin m_unf = 1; n_cpr = 0; end
            else begin m_cnt--; n_cpr = m_stk[m_cnt]; end
        end else if (cpr_we) begin
            n_cpr = int'(cpr_wdata);
        end
        m_irq = n_irq && !ack_ok;
        m_vec = idx;
        m_lvl = best;
        m_cpr = n_cpr;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "irq", int'(irq_o), int'(m_irq));
        if (m_irq) chk(tag, "vec", int'(vec_o), m_vec);
        chk(tag, "cpr", int'(cpr_o), m_cpr);
        chk(tag, "ovf", int'(ovf_o), int'(m_ovf));
        chk(tag, "unf", int'(unf_o), int'(m_unf));
    endtask

    task automatic idle();
        ack = 0; eoi = 0; cpr_we = 0; cpr_wdata = 0;
    endtask

    task automatic do_reset();
        idle();
        src_req = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic set_prio(input int i, input int p);
        src_prio[i*3 +: 3] = 3'(p);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        src_prio = 0;
        do_reset();
        // R10: state after reset
        chk("R10", "irq", int'(irq_o), 0);
        chk("R10", "cpr", int'(cpr_o), 0);
        chk("R10", "ovf", int'(ovf_o), 0);
        chk("R10", "unf", int'(unf_o), 0);

        // R9: acknowledge with no request, then pop shows the stack is empty
        ack = 1; step("R9");
        idle(); eoi = 1; step("R9");
        idle(); step("R8");

        // R2: zero-priority source alone
        do_reset();
        for (int i = 0; i < 8; i++) set_prio(i, 0);
        src_req = 8'b0000_1000; step("R2"); step("R2");

        // R3: tie between sources 2 and 5 at level 5, source 1 at level 3
        set_prio(1, 3); set_prio(2, 5); set_prio(5, 5);
        src_req = 8'b0010_0110; step("R3");
        chk("R3", "vec direct", int'(vec_o), 2);

        // R6: ceiling write while presented, then acknowledge still accepted
        cpr_we = 1; cpr_wdata = 6; step("R6");
        chk("R6", "irq held", int'(irq_o), 1);
        idle(); ack = 1; step("R4");
        chk("R4", "cpr level", int'(cpr_o), 5);
        // R5: pops restore the ceiling then the original level
        idle(); src_req = 0; eoi = 1; step("R5");
        chk("R5", "ceiling back", int'(cpr_o), 6);
        cpr_we = 1; cpr_wdata = 1; step("R5");
        idle(); eoi = 1; step("R8");
        idle(); step("R8");

        // R7: nine nested accepts overflow the 8-deep stack
        do_reset();
        set_prio(0, 7); src_req = 8'b0000_0001;
        for (int k = 0; k < 9; k++) begin
            idle(); step("R1");
            ack = 1; step("R7");
            idle(); cpr_we = 1; cpr_wdata = 0; step("R6");
        end
        idle(); src_req = 0;
        for (int k = 0; k < 9; k++) begin eoi = 1; step("R7"); end
        idle(); step("R8");

        // R11: coincident strobes
        do_reset();
        set_prio(4, 4); src_req = 8'b0001_0000;
        step("R11");
        ack = 1; eoi = 1; cpr_we = 1; cpr_wdata = 7; step("R11");
        ack = 0; step("R11");
        idle(); step("R11");

        // random mix, R1 arbitration and all updates
        do_reset();
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 8 == 0) src_prio = $urandom;
            src_req   = 8'($urandom);
            ack       = ($urandom % 10) < 3;
            eoi       = ($urandom % 10) < 2;
            cpr_we    = ($urandom % 10) < 1;
            cpr_wdata = 3'($urandom);
            step("R1");
        end
        idle();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule